// File: doc/BRIEF.md
# Dual Bridge-Sensor ADC Lockstep Reader

This block reads two 24-bit serial bridge-sensor converters that share one serial clock line and have separate data lines. After a request, it waits until both data lines are low, which is how each converter signals a finished conversion. It then issues a train of one-shot pulses on the shared clock and shifts one bit from each data line into its own accumulator on every data pulse.

Each read ends with one extra pulse that carries no data. This pulse keeps the converters in the channel/gain setting used for the next conversion. Both 24-bit results are sign-extended to 32 bits and published together with a one-cycle strobe. If the request is still high in that strobe cycle, the block goes straight on to wait for the next conversion, so reads run back to back for as long as the request is held.

The pulse period comes from dividing the system clock by the pulse rate. The high phase is half the period, rounded up.

Top module: `dual_bridge_adc_reader`

## Requirements
- R1: While reset is asserted and right after it, `sck`, `busy` and `valid` are 0 and both result outputs are 0.
- R2: A high `req` seen while idle raises `busy` in the next cycle. `busy` stays high up to and including the `valid` cycle. If `req` is low in the `valid` cycle, `busy` is 0 in the cycle after it.
- R3: No clock pulse of a read begins unless both data lines are low. While either line is high the block waits with `sck` low and does not abort.
- R4: Every read issues exactly 25 pulses on `sck`: 24 data pulses and then one trailing pulse. `sck` is low whenever `busy` is low.
- R5: With PERIOD = SYS_HZ / PULSE_HZ, each pulse is high for ceil(PERIOD/2) cycles and then low for the rest of PERIOD. Pulses within one read follow each other without extra gap.
- R6: One bit is taken from each data line after the falling edge of each of the first 24 pulses, in the last cycle of that pulse's low phase. The first bit is the most significant, and each new bit enters at the least significant end. The trailing pulse captures nothing.
- R7: Each 24-bit word is two's complement and is sign-extended to 32 bits: 0x7FFFFF gives 8388607, 0x800000 gives -8388608, 0xFFFFFF gives -1, 0x000000 gives 0.
- R8: Both results change in the same cycle, and only in a cycle where `valid` is high. `valid` lasts exactly one cycle and is raised in the cycle directly after the full period of the trailing pulse.
- R9: If `req` is still high in the `valid` cycle, the next read starts without returning to idle. If `req` is low, the block goes idle and issues no pulses until the next request.
- R10: `value_a` is built only from `sdo_a`, and `value_b` only from `sdo_b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Read request, sampled while idle and in the valid cycle |
| sdo_a | input | 1 | Data / ready line of converter A (low = ready) |
| sdo_b | input | 1 | Data / ready line of converter B (low = ready) |
| sck | output | 1 | Shared serial clock, idle low |
| busy | output | 1 | High from accepted request until the valid cycle |
| valid | output | 1 | One-cycle strobe marking new results |
| value_a | output | 32 | Sign-extended result of converter A |
| value_b | output | 32 | Sign-extended result of converter B |

## Verification
The bench models two converters that answer `sck` rising edges by presenting their next bit, MSB first. They are loaded with words at the sign boundaries (zero, most positive, most negative, minus one, minus two) and with irregular patterns. Converter A always gets a different word from converter B, so a swapped or shared channel shows up as a wrong value. One converter is held not-ready for a long time between reads, which separates "waits for both" from "waits for either". Reads are run both with the request held high (back to back) and with single-cycle requests followed by idle gaps, which separates the continue-versus-idle decision in the valid cycle. An odd pulse period is used, so a wrong rounding of the high phase changes the measured widths.

// File: rtl/dual_bridge_adc_reader.sv
module dual_bridge_adc_reader #(
  parameter int unsigned SYS_HZ       = 100_000_000,
  parameter int unsigned PULSE_HZ     = 500_000,
  parameter int unsigned DATA_BITS    = 24,
  parameter int unsigned TRAIL_PULSES = 1,
  parameter int unsigned OUT_W        = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    sdo_a,
  input  logic                    sdo_b,
  output logic                    sck,
  output logic                    busy,
  output logic                    valid,
  output logic signed [OUT_W-1:0] value_a,
  output logic signed [OUT_W-1:0] value_b
);
  localparam int unsigned PERIOD = SYS_HZ / PULSE_HZ;
  localparam int unsigned HIGH   = (PERIOD + 1) / 2;
  localparam int unsigned TOTAL  = DATA_BITS + TRAIL_PULSES;
  localparam int unsigned CW     = $clog2(PERIOD + 1);
  localparam int unsigned PW     = $clog2(TOTAL + 1);
  localparam int unsigned EXT    = OUT_W - DATA_BITS;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_PULSE, ST_DONE} state_t;

  state_t               state;
  logic [CW-1:0]        cnt;
  logic [PW-1:0]        idx;
  logic [1:0]           sync_a, sync_b;
  logic [DATA_BITS-1:0] acc_a, acc_b;

  wire both_ready = !sync_a[1] && !sync_b[1];
  wire period_end = (cnt == CW'(PERIOD - 1));
  wire capture    = period_end && (idx < PW'(DATA_BITS));
  wire last_pulse = period_end && (idx == PW'(TOTAL - 1));

  assign sck   = (state == ST_PULSE) && (cnt < CW'(HIGH));
  assign busy  = (state != ST_IDLE);
  assign valid = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= 2'b11;
      sync_b <= 2'b11;
    end else begin
      sync_a <= {sync_a[0], sdo_a};
      sync_b <= {sync_b[0], sdo_b};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      acc_a   <= '0;
      acc_b   <= '0;
      value_a <= '0;
      value_b <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req) state <= ST_WAIT;
        ST_WAIT: begin
          cnt <= '0;
          idx <= '0;
          if (both_ready) state <= ST_PULSE;
        end
        ST_PULSE: begin
          if (period_end) begin
            cnt <= '0;
            idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
          if (capture) begin
            acc_a <= {acc_a[DATA_BITS-2:0], sync_a[1]};
            acc_b <= {acc_b[DATA_BITS-2:0], sync_b[1]};
          end
          if (last_pulse) begin
            value_a <= {{EXT{acc_a[DATA_BITS-1]}}, acc_a};
            value_b <= {{EXT{acc_b[DATA_BITS-1]}}, acc_b};
            state   <= ST_DONE;
          end
        end
        default: state <= req ? ST_WAIT : ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_bridge_adc_reader_chk.sv
module dual_bridge_adc_reader_chk #(
  parameter int unsigned HIGH_CYC  = 100,
  parameter int unsigned DATA_BITS = 24,
  parameter int unsigned OUT_W     = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req,
  input logic                    sck,
  input logic                    busy,
  input logic                    valid,
  input logic signed [OUT_W-1:0] value_a,
  input logic signed [OUT_W-1:0] value_b
);
  localparam int unsigned XW = OUT_W - DATA_BITS + 1;

  int unsigned hcnt;
  always_ff @(posedge clk) begin
    if (!rst_n)   hcnt <= 0;
    else if (sck) hcnt <= hcnt + 1;
    else          hcnt <= 0;
  end

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));

  assert_busy_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> busy);

  assert_single_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(value_a) && $stable(value_b)));

  assert_high_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (hcnt == HIGH_CYC));

  assert_sign_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((value_a[OUT_W-1:DATA_BITS-1] == '0 || value_a[OUT_W-1:DATA_BITS-1] == {XW{1'b1}}) &&
               (value_b[OUT_W-1:DATA_BITS-1] == '0 || value_b[OUT_W-1:DATA_BITS-1] == {XW{1'b1}})));
endmodule

bind dual_bridge_adc_reader dual_bridge_adc_reader_chk #(
  .HIGH_CYC(HIGH), .DATA_BITS(DATA_BITS), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .sck(sck), .busy(busy),
  .valid(valid), .value_a(value_a), .value_b(value_b)
);

// File: tb/tb_dual_bridge_adc_reader.sv
module tb_dual_bridge_adc_reader;
  localparam int unsigned SYS_HZ   = 3_500_000;
  localparam int unsigned PULSE_HZ = 500_000;
  localparam int PER  = 7;
  localparam int HI   = 4;
  localparam int LO   = PER - HI;
  localparam int NW   = 8;

  logic clk = 0, rst_n = 0, req = 0;
  logic sdo_a = 0, sdo_b = 0;
  logic sck, busy, valid;
  logic signed [31:0] value_a, value_b;

  dual_bridge_adc_reader #(.SYS_HZ(SYS_HZ), .PULSE_HZ(PULSE_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .sdo_a(sdo_a), .sdo_b(sdo_b),
    .sck(sck), .busy(busy), .valid(valid), .value_a(value_a), .value_b(value_b));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req_tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req_tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] sx(input logic [23:0] w);
    longint v;
    v = (w >= 24'h800000) ? longint'(w) - 64'd16777216 : longint'(w);
    return 32'(v);
  endfunction

  logic [23:0] wa [NW];
  logic [23:0] wb [NW];
  initial begin
    wa[0]=24'h000000; wa[1]=24'h7FFFFF; wa[2]=24'h800000; wa[3]=24'hFFFFFF;
    wa[4]=24'h123456; wa[5]=24'hA5A5A5; wa[6]=24'h000001; wa[7]=24'h800001;
    wb[0]=24'hFFFFFF; wb[1]=24'h000000; wb[2]=24'h7FFFFF; wb[3]=24'h800000;
    wb[4]=24'h654321; wb[5]=24'h5A5A5A; wb[6]=24'hFFFFFE; wb[7]=24'h400000;
  end

  // Converter models and per-clock reference comparison
  int ia = 0, ib = 0, rdy_a = 1, rdy_b = 1, dla = 0, dlb = 0;
  int pulses = 0, nvalid = 0, rises = 0, hrun = 0, lrun = 0;
  logic prev_sck = 0;
  logic [31:0] last_a = 0, last_b = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sck && !prev_sck) begin
        rises++;
        chk(busy == 1, "R2 busy during pulse", busy, 1);
        if (pulses == 0)
          chk(sdo_a == 0 && sdo_b == 0, "R3 start needs both ready", {sdo_a, sdo_b}, 0);
        else
          chk(lrun == LO, "R5 low phase", lrun, LO);
        if (pulses < 24) begin
          sdo_a <= wa[ia][23-pulses];
          sdo_b <= wb[ib][23-pulses];
        end else begin
          sdo_a <= 1; sdo_b <= 1; rdy_a = 0; rdy_b = 0;
          ia++; ib++;
          dla = 3;
          dlb = (ib == 2) ? 40 : 6;
        end
        pulses++;
        hrun = 1;
      end else if (sck) begin
        hrun++;
      end else if (prev_sck) begin
        chk(hrun == HI, "R5 high phase", hrun, HI);
        lrun = 1;
      end else begin
        lrun++;
      end
      if (!busy) chk(sck == 0, "R4 idle low", sck, 0);
      if (!rdy_a) begin
        if (dla > 0) dla--;
        else if (ia < NW) begin rdy_a = 1; sdo_a <= 0; end
      end
      if (!rdy_b) begin
        if (dlb > 0) dlb--;
        else if (ib < NW) begin rdy_b = 1; sdo_b <= 0; end
      end
      if (valid) begin
        chk(pulses == 25, "R4 pulse count", pulses, 25);
        chk(lrun == LO + 1, "R8 valid after trailing pulse", lrun, LO + 1);
        chk(busy == 1, "R2 busy in valid cycle", busy, 1);
        chk(value_a == sx(wa[nvalid]), "R6 R7 R10 value_a", value_a, sx(wa[nvalid]));
        chk(value_b == sx(wb[nvalid]), "R6 R7 R10 value_b", value_b, sx(wb[nvalid]));
        nvalid++;
        pulses = 0;
        last_a = value_a; last_b = value_b;
      end else begin
        chk(value_a == last_a && value_b == last_b, "R8 hold", value_a, last_a);
      end
      prev_sck = sck;
    end
  end

  task automatic wait_valid;
    do begin @(posedge clk); #1; end while (!valid);
  endtask

  task automatic idle_check(input int n);
    int r0;
    r0 = rises;
    repeat (n) @(posedge clk);
    #1;
    chk(busy == 0, "R9 idle busy", busy, 0);
    chk(rises == r0, "R9 no pulses while idle", rises - r0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(sck == 0 && busy == 0 && valid == 0, "R1 reset outputs", {sck, busy, valid}, 0);
    chk(value_a == 0 && value_b == 0, "R1 reset values", value_a, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk(busy == 0 && sck == 0, "R1 after reset", busy, 0);
    req = 1;
    @(posedge clk); #1;
    chk(busy == 1, "R2 accept", busy, 1);
    for (int i = 0; i < 6; i++) wait_valid();
    req = 0;
    @(posedge clk); #1;
    chk(busy == 0, "R2 busy drops after valid", busy, 0);
    idle_check(40);
    for (int k = 0; k < 2; k++) begin
      req = 1;
      @(posedge clk); #1;
      req = 0;
      chk(busy == 1, "R2 single-cycle request", busy, 1);
      wait_valid();
      @(posedge clk); #1;
      chk(busy == 0, "R9 returns idle", busy, 0);
      idle_check(30);
    end
    chk(nvalid == 8, "R9 read count", nvalid, 8);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", nvalid, 8);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule